// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block models a byte-wide serial EEPROM that answers as a target on a two-wire (I2C) bus. It runs on a fast system clock. It oversamples the clock and data lines through synchronisers and pulls the data line low through an open-drain style enable. A host selects it with an address byte. For writes, the host then sends a two-byte word address and the data bytes. For reads, the host issues a new address byte with the read bit set and clocks bytes out of the array.

Writes collect in a page buffer. A stop condition hands the buffer to a self-timed programming cycle whose length is a parameter. While that cycle runs, the target ignores its own address, so the host can poll until the write is done. A block-select bit in the address byte picks one of two equal banks, and sequential access never leaves the bank it is in. A write-protect input turns the device into a read-only memory.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset the target does not pull the data line low, the bus logic is idle and every array byte reads 8'hFF.
- R2: The address byte is, MSB first, a 4-bit code that must equal 4'b1010, a block-select bit, the two chip-select bits A1 then A0, and the read/write bit (1 = read). The target acknowledges it only when the code matches, both chip-select bits equal the strap inputs and the A2 strap is high. Otherwise it does not drive the data line until the next start condition.
- R3: Each byte the target accepts (address byte, both word-address bytes, write data) is acknowledged by pulling the data line low for the ninth clock. The target changes the data line only while the clock line is low.
- R4: A write sends the high word-address byte, then the low one, then data. A stop after at least one data byte starts a programming cycle of PROG_CYCLES clocks, and the buffered bytes appear in the array when it ends.
- R5: While a programming cycle runs, the target does not acknowledge its address byte.
- R6: Write data past the last byte of a PAGE_BYTES page wraps to the first byte of that same page. A later byte to the same location replaces the earlier one.
- R7: After a word address is set, a repeated start with a read address byte returns bytes from that address upward, one per byte clocked out.
- R8: A read without a new word address continues from the byte after the last one read.
- R9: The block-select bit is the top array address bit and selects one of two equal banks. Sequential reads past the last byte of a bank wrap to the first byte of the same bank.
- R10: With write-protect high, data bytes are still acknowledged, but no programming cycle starts, the array does not change and the address byte is acknowledged right after the stop.
- R11: A host not-acknowledge after a read byte ends the read. The target releases the data line and waits for the next start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen on the wire |
| sdaIn | input | 1 | Bus data line as seen on the wire |
| sdaPullLow | output | 1 | 1 pulls the data line low; 0 releases it |
| strapA2 | input | 1 | Must be high for the target to answer |
| strapA1 | input | 1 | Chip-select strap compared with address bit A1 |
| strapA0 | input | 1 | Chip-select strap compared with address bit A0 |
| writeProtect | input | 1 | High makes the array read-only |

## Verification
On every cycle the assertions check four things: the data line moves only while the clock line is low, the address byte is refused while programming is under way, a host refusal ends a read with the line released, and a programming cycle never starts under write protect. They also check that pointer steps stay inside the current page on writes and inside the bank on reads. Only the bench's scenarios can show the stored contents: page wrap-around with overwrite, the bank-confined read wrap, current-address continuation, the polling count across a programming cycle, and an array left unchanged by a protected write.

// File: rtl/i2cee_pkg.sv
package i2cee_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_ADRH, ST_ADRL, ST_WDAT, ST_RDAT, ST_WAIT
  } busState_t;

  typedef struct packed {
    logic       selBank;
    logic       bankBit;
    logic       ldHi;
    logic       ldLo;
    logic       wrByte;
    logic       incPtr;
    logic       commit;
    logic       drop;
    logic [7:0] data;
  } dpStrobe_t;
endpackage

// File: rtl/i2cee_ctrl.sv
module i2cee_ctrl
  import i2cee_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       strapA2,
  input  logic       strapA1,
  input  logic       strapA0,
  input  logic       busy,
  input  logic [7:0] rdData,
  output dpStrobe_t  strb,
  output logic       sdaPullLow
);
  logic sclM, sclS, sclP, sdaM, sdaS, sdaP;
  logic sclRise, sclFall, startSeen, stopSeen;
  busState_t state;
  logic [3:0] bitCnt;
  logic [7:0] shReg, txReg;
  logic ackPhase, rdMode, hostAck, devHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {sclM, sclS, sclP} <= 3'b111;
      {sdaM, sdaS, sdaP} <= 3'b111;
    end else begin
      sclM <= sclIn; sclS <= sclM; sclP <= sclS;
      sdaM <= sdaIn; sdaS <= sdaM; sdaP <= sdaS;
    end
  end

  assign sclRise   = sclS & ~sclP;
  assign sclFall   = ~sclS & sclP;
  assign startSeen = sclS & sclP & sdaP & ~sdaS;
  assign stopSeen  = sclS & sclP & ~sdaP & sdaS;
  assign devHit    = (shReg[7:4] == DEV_CODE) && (shReg[2:1] == {strapA1, strapA0})
                     && strapA2 && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; bitCnt <= '0; shReg <= '0; txReg <= '0;
      ackPhase <= 1'b0; rdMode <= 1'b0; hostAck <= 1'b0;
      sdaPullLow <= 1'b0; strb <= '0;
    end else begin
      strb <= '0;
      if (startSeen) begin
        if (state == ST_WDAT) strb.drop <= 1'b1;
        state <= ST_DEV; bitCnt <= '0; ackPhase <= 1'b0; sdaPullLow <= 1'b0;
      end else if (stopSeen) begin
        if (state == ST_WDAT) strb.commit <= 1'b1;
        state <= ST_IDLE; bitCnt <= '0; ackPhase <= 1'b0; sdaPullLow <= 1'b0;
      end else if (state == ST_DEV || state == ST_ADRH || state == ST_ADRL || state == ST_WDAT) begin
        if (sclRise && !ackPhase && bitCnt != 4'd8) begin
          shReg  <= {shReg[6:0], sdaS};
          bitCnt <= bitCnt + 4'd1;
        end
        if (sclFall && !ackPhase && bitCnt == 4'd8) begin
          if (state == ST_DEV && !devHit) begin
            state <= ST_WAIT;
          end else begin
            ackPhase   <= 1'b1;
            sdaPullLow <= 1'b1;
            strb.data  <= shReg;
            if (state == ST_DEV) begin
              strb.selBank <= 1'b1;
              strb.bankBit <= shReg[3];
              rdMode       <= shReg[0];
            end else if (state == ST_ADRH) begin
              strb.ldHi <= 1'b1;
            end else if (state == ST_ADRL) begin
              strb.ldLo <= 1'b1;
            end else begin
              strb.wrByte <= 1'b1;
            end
          end
        end
        if (sclFall && ackPhase) begin
          ackPhase   <= 1'b0;
          sdaPullLow <= 1'b0;
          bitCnt     <= '0;
          if (state == ST_DEV) begin
            if (rdMode) begin
              state      <= ST_RDAT;
              txReg      <= rdData;
              sdaPullLow <= ~rdData[7];
              bitCnt     <= 4'd1;
            end else begin
              state <= ST_ADRH;
            end
          end else if (state == ST_ADRH) begin
            state <= ST_ADRL;
          end else if (state == ST_ADRL) begin
            state <= ST_WDAT;
          end
        end
      end else if (state == ST_RDAT) begin
        if (sclFall && !ackPhase) begin
          if (bitCnt != 4'd8) begin
            sdaPullLow <= ~txReg[6];
            txReg      <= {txReg[6:0], 1'b0};
            bitCnt     <= bitCnt + 4'd1;
          end else begin
            sdaPullLow  <= 1'b0;
            ackPhase    <= 1'b1;
            strb.incPtr <= 1'b1;
          end
        end
        if (sclRise && ackPhase) hostAck <= ~sdaS;
        if (sclFall && ackPhase) begin
          ackPhase <= 1'b0;
          if (hostAck) begin
            txReg      <= rdData;
            sdaPullLow <= ~rdData[7];
            bitCnt     <= 4'd1;
          end else begin
            sdaPullLow <= 1'b0;
            state      <= ST_WAIT;
          end
        end
      end
    end
  end

  // R3: the data line only moves while the clock line is low
  a_r3_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullLow) |-> !sclS);

  // R5: address byte refused during programming
  a_r5_no_ack_busy: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEV && sclFall && !ackPhase && bitCnt == 4'd8 && busy) |=> !sdaPullLow);

  // R11: host refusal ends the read with the line released
  a_r11_nack_release: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RDAT && ackPhase && sclFall && !hostAck && !startSeen && !stopSeen)
      |=> (!sdaPullLow && state == ST_WAIT));

  // R4: at most one datapath action per cycle
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.selBank, strb.ldHi, strb.ldLo, strb.wrByte, strb.incPtr, strb.commit, strb.drop}));
endmodule

// File: rtl/i2cee_dp.sv
module i2cee_dp
  import i2cee_pkg::*;
#(
  parameter int MEM_BYTES   = 1024,
  parameter int PAGE_BYTES  = 128,
  parameter int PROG_CYCLES = 5000
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  strb,
  input  logic       writeProtect,
  output logic       busy,
  output logic [7:0] rdData
);
  localparam int BANK_BYTES = MEM_BYTES / 2;
  localparam int BANK_AW    = $clog2(BANK_BYTES);
  localparam int PAGE_AW    = $clog2(PAGE_BYTES);
  localparam int CNT_W      = $clog2(PROG_CYCLES + 1);
  localparam logic [BANK_AW-1:0] BANK_LAST = '1;

  logic [7:0]  mem [MEM_BYTES];
  logic [7:0]  pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pageVld;
  logic        bankSel, wrBank;
  logic [7:0]  hiByte;
  logic [BANK_AW-1:0] offset;
  logic [BANK_AW-PAGE_AW-1:0] wrPage;
  logic [CNT_W-1:0] progCnt;
  logic        progDone;

  assign rdData   = mem[{bankSel, offset}];
  assign progDone = busy && (progCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankSel <= 1'b0; wrBank <= 1'b0; hiByte <= '0; offset <= '0;
      wrPage <= '0; pageVld <= '0; busy <= 1'b0; progCnt <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pageBuf[i] <= '0;
    end else begin
      if (strb.selBank) bankSel <= strb.bankBit;
      if (strb.ldHi) hiByte <= strb.data;
      if (strb.ldLo) begin
        offset  <= BANK_AW'({hiByte, strb.data});
        wrPage  <= BANK_AW'({hiByte, strb.data}) >> PAGE_AW;
        wrBank  <= bankSel;
        pageVld <= '0;
      end
      if (strb.wrByte) begin
        pageBuf[offset[PAGE_AW-1:0]] <= strb.data;
        pageVld[offset[PAGE_AW-1:0]] <= 1'b1;
        offset[PAGE_AW-1:0]          <= offset[PAGE_AW-1:0] + PAGE_AW'(1);
      end
      if (strb.incPtr) offset <= offset + BANK_AW'(1);
      if (strb.drop) pageVld <= '0;
      if (strb.commit) begin
        if (!writeProtect && (|pageVld)) begin
          busy    <= 1'b1;
          progCnt <= CNT_W'(PROG_CYCLES - 1);
        end else begin
          pageVld <= '0;
        end
      end
      if (busy) begin
        if (progDone) begin
          busy    <= 1'b0;
          pageVld <= '0;
        end else begin
          progCnt <= progCnt - CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else if (progDone) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (pageVld[i]) mem[{wrBank, wrPage, PAGE_AW'(i)}] <= pageBuf[i];
    end
  end

  // R10: programming never starts while protected
  a_r10_wp_no_prog: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !$past(writeProtect));

  // R9: read pointer wraps within its bank
  a_r9_bank_wrap: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.incPtr) && $past(offset) == BANK_LAST)
      |-> (offset == '0 && bankSel == $past(bankSel)));

  // R6: write steps never leave the page
  a_r6_page_stay: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.wrByte) |-> (offset[BANK_AW-1:PAGE_AW] == $past(offset[BANK_AW-1:PAGE_AW])));
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import i2cee_pkg::*;
#(
  parameter int MEM_BYTES   = 1024,
  parameter int PAGE_BYTES  = 128,
  parameter int PROG_CYCLES = 5000
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaPullLow,
  input  logic strapA2,
  input  logic strapA1,
  input  logic strapA0,
  input  logic writeProtect
);
  dpStrobe_t  strb;
  logic       busy;
  logic [7:0] rdData;

  i2cee_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .strapA2(strapA2), .strapA1(strapA1), .strapA0(strapA0),
    .busy(busy), .rdData(rdData), .strb(strb), .sdaPullLow(sdaPullLow)
  );

  i2cee_dp #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .writeProtect(writeProtect),
    .busy(busy), .rdData(rdData)
  );
endmodule

// File: tb/sim_i2c_eeprom_target.sv
module sim_i2c_eeprom_target;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 20;

  typedef struct { string tag; int val; } item_t;

  logic clk = 1'b0, rstN = 1'b0, scl = 1'b1, hostLow = 1'b0;
  logic a2 = 1'b1, a1 = 1'b1, a0 = 1'b0, wp = 1'b0;
  logic sdaPull, sdaBus;
  int checks = 0, errors = 0;
  bit done = 0;
  item_t expQ[$];
  int actQ[$];

  assign sdaBus = !(hostLow || sdaPull);
  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_eeprom_target #(.MEM_BYTES(256), .PAGE_BYTES(8), .PROG_CYCLES(2000)) u0 (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus), .sdaPullLow(sdaPull),
    .strapA2(a2), .strapA1(a1), .strapA0(a0), .writeProtect(wp)
  );

  task automatic waitN(int n); repeat (n) @(negedge clk); endtask

  task automatic direct(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  initial begin : monitor
    forever begin
      item_t e; int a;
      wait (actQ.size() > 0);
      a = actQ.pop_front();
      e = expQ.pop_front();
      direct(e.tag, a, e.val);
    end
  end

  task automatic startBit();
    hostLow = 0; waitN(HALF); scl = 1; waitN(HALF);
    hostLow = 1; waitN(HALF); scl = 0; waitN(HALF/2);
  endtask

  task automatic stopBit();
    hostLow = 1; waitN(HALF); scl = 1; waitN(HALF); hostLow = 0; waitN(HALF);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      hostLow = !b[i]; waitN(HALF); scl = 1; waitN(HALF); scl = 0;
    end
    hostLow = 0; waitN(HALF); scl = 1; waitN(HALF/2);
    ack = !sdaBus; waitN(HALF/2); scl = 0;
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] b);
    hostLow = 0;
    for (int i = 0; i < 8; i++) begin
      waitN(HALF); scl = 1; waitN(HALF/2); b = {b[6:0], sdaBus}; waitN(HALF/2); scl = 0;
    end
    waitN(4); hostLow = giveAck; waitN(HALF); scl = 1; waitN(HALF); scl = 0; waitN(4); hostLow = 0;
  endtask

  task automatic sendChk(logic [7:0] b, int expAck, string tag);
    bit ack;
    expQ.push_back('{tag, expAck});
    sendByte(b, ack);
    actQ.push_back(int'(ack));
  endtask

  task automatic recvChk(int expVal, bit giveAck, string tag);
    logic [7:0] b;
    expQ.push_back('{tag, expVal});
    recvByte(giveAck, b);
    actQ.push_back(int'(b));
  endtask

  task automatic setAddr(logic [7:0] ctrlW, logic [7:0] hi, logic [7:0] lo);
    startBit();
    sendChk(ctrlW, 1, "R2 address ack");
    sendChk(hi, 1, "R3 high address ack");
    sendChk(lo, 1, "R3 low address ack");
  endtask

  task automatic readFrom(logic [7:0] ctrlW, logic [7:0] hi, logic [7:0] lo,
                          int expv[$], string tag);
    setAddr(ctrlW, hi, lo);
    startBit();
    sendChk(ctrlW | 8'h01, 1, "R7 read address ack");
    foreach (expv[i]) recvChk(expv[i], i != expv.size() - 1, tag);
    stopBit();
  endtask

  task automatic pollReady(output int nacks);
    bit ack;
    nacks = 0;
    do begin
      startBit(); sendByte(8'hA4, ack); stopBit();
      if (!ack) nacks++;
    end while (!ack && nacks < 40);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    int n;
    waitN(5); rstN = 1; waitN(5);
    direct("R1 line released after reset", int'(sdaPull), 0);
    readFrom(8'hA4, 8'h00, 8'h20, '{8'hFF}, "R1 erased byte");

    // R2: wrong code, chip-select mismatch, A2 strap low
    startBit(); sendChk(8'hB4, 0, "R2 wrong code nack"); stopBit();
    startBit(); sendChk(8'hA0, 0, "R2 chip-select mismatch nack"); stopBit();
    a2 = 0; startBit(); sendChk(8'hA4, 0, "R2 A2 strap low nack"); stopBit(); a2 = 1;

    // R4/R5: byte write then polling
    setAddr(8'hA4, 8'h00, 8'h10);
    sendChk(8'h11, 1, "R3 data ack");
    sendChk(8'h22, 1, "R3 data ack");
    sendChk(8'h33, 1, "R3 data ack");
    stopBit();
    pollReady(n);
    direct("R5 nack while programming", int'(n >= 2), 1);
    direct("R4 programming ends", int'(n < 40), 1);
    readFrom(8'hA4, 8'h00, 8'h10, '{8'h11, 8'h22, 8'h33}, "R7 sequential read");

    // R6: page wrap with overwrite
    setAddr(8'hA4, 8'h00, 8'h06);
    for (int i = 0; i < 10; i++) sendChk(8'hA0 + i[7:0], 1, "R3 page data ack");
    stopBit(); pollReady(n);
    readFrom(8'hA4, 8'h00, 8'h00,
      '{8'hA2, 8'hA3, 8'hA4, 8'hA5, 8'hA6, 8'hA7, 8'hA8, 8'hA9, 8'hFF}, "R6 page wrap");

    // R9: bank confinement
    setAddr(8'hA4, 8'h00, 8'h7F); sendChk(8'h3C, 1, "R3 data ack"); stopBit(); pollReady(n);
    setAddr(8'hAC, 8'h00, 8'h7F); sendChk(8'h5A, 1, "R3 data ack"); stopBit(); pollReady(n);
    readFrom(8'hA4, 8'h00, 8'h7F, '{8'h3C, 8'hA2}, "R9 bank0 wrap");

    // R8: current address read continues at offset 1 of bank 0
    startBit(); sendChk(8'hA5, 1, "R8 read address ack");
    recvChk(8'hA3, 0, "R8 current address"); stopBit();
    direct("R11 line released after nack", int'(sdaPull), 0);

    readFrom(8'hAC, 8'h00, 8'h7F, '{8'h5A, 8'hFF}, "R9 bank1 wrap");

    // R10: write protect
    wp = 1;
    setAddr(8'hA4, 8'h00, 8'h10); sendChk(8'h99, 1, "R10 protected data ack"); stopBit();
    startBit(); sendChk(8'hA4, 1, "R10 not busy after protected write"); stopBit();
    wp = 0;
    readFrom(8'hA4, 8'h00, 8'h10, '{8'h11}, "R10 array unchanged");

    wait (actQ.size() == 0);
    waitN(10);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule